// File: doc/BRIEF.md
# Shadowed SRAM Mode Controller

This block is a clocked model of a byte-wide static RAM with a nonvolatile shadow copy of the same size. When it is ready, it behaves as a plain SRAM. It has active-low chip enable, output enable and write enable. A read drives the output bus, and a write is committed when its cycle closes. A falling edge on the active-low hardware-store input moves the block into nonvolatile mode. In that mode it first erases the shadow array and then programs it with the SRAM contents.

A power-good input stands in for supply sensing. While it is low, the block sits in an off state, the SRAM copy is treated as lost, and a recall request is held. When power-good returns, the block copies the shadow array back into the SRAM over a fixed number of cycles. While it stores or recalls, all SRAM access is locked out and the busy output is high. If a write is still being requested when a recall finishes, a corruption flag is raised and that write is discarded.

The states of the sequencer are OFF, RESTORE, READY, ERASE and PROGRAM. Its transitions are:
- Loss of power-good moves any state to OFF.
- OFF moves to RESTORE when power-good is high and a recall request is pending.
- RESTORE moves to READY when its counter expires, which completes the recall.
- READY moves to ERASE when hardware-store falls.
- ERASE moves to PROGRAM when its counter expires, which clears the shadow array.
- PROGRAM moves to READY when its counter expires, which copies the SRAM into the shadow array.

The address width is a parameter. A full-size 32K x 8 instance sets it to 15, and the default is kept small.

Top module: `nvs_ctrl`

## Requirements
- R1: While reset is held, `busy`, `dout_en` and `corrupt` are low. Reset leaves a recall pending. With `pwr_good` high, the cycle after reset release enters RESTORE, and `busy` stays high for exactly RESTORE_CYC cycles. After that recall the SRAM reads all zero, because the shadow array resets to zero.
- R2: `dout_en` is high only in READY while `ce_n` and `oe_n` are low and `we_n` and `hs_n` are high. While it is high, `dout` shows the byte at the current `addr` and follows changes of `addr` without any change on the controls. `dout` is zero whenever `dout_en` is low.
- R3: A write cycle is open while `ce_n` and `we_n` are both low and `hs_n` is high in READY. The byte is stored at the clock edge after `ce_n` or `we_n` rises. It uses the address and data sampled in the last cycle the write was open, so a cycle may be ended by either `we_n` or `ce_n`.
- R4: While `ce_n` and `we_n` are both low, `dout_en` is low even if `oe_n` is low.
- R5: A falling edge of `hs_n` in READY starts a STORE. `busy` is high for exactly ERASE_CYC cycles of erase followed by PROG_CYC cycles of program. Afterwards the shadow array holds the SRAM contents as they stood at the end of the program phase.
- R6: While `busy` is high, `dout_en` stays low and write cycles leave the SRAM unchanged.
- R7: When `pwr_good` goes low, the block enters OFF. In OFF, `dout_en` and `busy` are low and a recall is latched. When `pwr_good` returns, `busy` is high for RESTORE_CYC cycles, and the SRAM then equals the shadow array. Writes made after the last STORE are lost.
- R8: If `ce_n` and `we_n` are low with `hs_n` high in the cycle a recall completes, `corrupt` goes high and that write is not stored. New writes are accepted after the write request has been released. `corrupt` clears when the next recall starts.
- R9: Holding `hs_n` low through and after a STORE does not start another STORE. Only a new falling edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | High while supply is adequate |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hs_n | input | 1 | Hardware store request, active low, falling edge acts |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Output drive enable |
| busy | output | 1 | High during erase, program and restore |
| corrupt | output | 1 | Write overlapped the end of a recall |

## Verification
- **Wrong state or counter.** A sequencer stuck in the wrong state, or with a wrong counter load, changes the number of cycles `busy` stays high. It also enables or blocks `dout_en` in the wrong window. Both effects are visible within a single STORE or recall.
- **Wrong copy or lost write.** A wrong bulk copy, or a write captured at the wrong time, shows only on the next read of the affected address. For shadow data, that read comes after a power cycle. The directed tests therefore read back every address they touch right after each STORE, power cycle and overlapped write.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_RESTORE,
        ST_READY,
        ST_ERASE,
        ST_PROGRAM
    } nvs_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int ERASE_CYC   = 8,
    parameter int PROG_CYC    = 12,
    parameter int RESTORE_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic hs_n,
    output logic ready,
    output logic busy,
    output logic erase_done,
    output logic prog_done,
    output logic recall_start,
    output logic recall_done
);
    localparam int MAXC  = max3(ERASE_CYC, PROG_CYC, RESTORE_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    nvs_state_e        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic              hs_prev;
    logic              rcl_req;

    // next-state logic
    always_comb begin
        nxt = state;
        if (!pwr_good) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:     if (rcl_req) nxt = ST_RESTORE;
                ST_RESTORE: if (cnt == '0) nxt = ST_READY;
                ST_READY:   if (!hs_n && hs_prev) nxt = ST_ERASE;
                ST_ERASE:   if (cnt == '0) nxt = ST_PROGRAM;
                ST_PROGRAM: if (cnt == '0) nxt = ST_READY;
                default:    nxt = ST_OFF;
            endcase
        end
    end

    // state register, phase counter, edge and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            cnt     <= '0;
            hs_prev <= 1'b1;
            rcl_req <= 1'b1;
        end else begin
            state   <= nxt;
            hs_prev <= hs_n;
            if (!pwr_good)
                rcl_req <= 1'b1;
            else if (state == ST_OFF && nxt == ST_RESTORE)
                rcl_req <= 1'b0;
            if (nxt != state) begin
                unique case (nxt)
                    ST_RESTORE: cnt <= CNT_W'(RESTORE_CYC - 1);
                    ST_ERASE:   cnt <= CNT_W'(ERASE_CYC - 1);
                    ST_PROGRAM: cnt <= CNT_W'(PROG_CYC - 1);
                    default:    cnt <= '0;
                endcase
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ready        = (state == ST_READY);
        busy         = (state == ST_RESTORE) || (state == ST_ERASE) || (state == ST_PROGRAM);
        erase_done   = (state == ST_ERASE)   && (nxt == ST_PROGRAM);
        prog_done    = (state == ST_PROGRAM) && (nxt == ST_READY);
        recall_done  = (state == ST_RESTORE) && (nxt == ST_READY);
        recall_start = (state == ST_OFF)     && (nxt == ST_RESTORE);
    end

    // R7: loss of power always lands in OFF
    a_r7_off_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> state == ST_OFF);

    // R5: program phase is only reached through erase
    a_r5_program_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROGRAM) |-> ($past(state) == ST_ERASE || $past(state) == ST_PROGRAM));

    // R9: a store starts only from READY
    a_r9_store_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_ERASE) |-> $past(state) == ST_READY);
endmodule

// File: rtl/nvs_access.sv
module nvs_access #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              recall_start,
    input  logic              recall_done,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              hs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              corrupt
);
    logic write_req;
    logic wr_open;
    logic hold_off;

    assign write_req = !ce_n && !we_n && hs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_open  <= 1'b0;
            hold_off <= 1'b0;
            corrupt  <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_open <= ready && write_req && !hold_off;
            if (ready && write_req && !hold_off) begin
                wr_addr <= addr;
                wr_data <= din;
            end
            if (recall_done && write_req)
                hold_off <= 1'b1;
            else if (!write_req)
                hold_off <= 1'b0;
            if (recall_done && write_req)
                corrupt <= 1'b1;
            else if (recall_start)
                corrupt <= 1'b0;
        end
    end

    always_comb begin
        wr_en   = wr_open && ready && hs_n && (ce_n || we_n);
        dout_en = ready && !ce_n && !oe_n && we_n && hs_n;
        rd_addr = addr;
        dout    = dout_en ? rd_data : '0;
    end

    // R4: no output drive while a write is requested
    a_r4_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |-> !dout_en);

    // R8: overlap of a write with recall completion raises the flag
    a_r8_flag_on_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (recall_done && write_req) |=> corrupt);
endmodule

// File: rtl/nvs_store.sv
module nvs_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_lost,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              do_erase,
    input  logic              do_program,
    input  logic              do_recall
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] sram   [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];
    logic              valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sram[i] <= '0;
        end else if (do_recall) begin
            sram <= shadow;
        end else if (wr_en) begin
            sram[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
        end else if (do_erase) begin
            for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
        end else if (do_program) begin
            shadow <= sram;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         valid <= 1'b0;
        else if (pwr_lost)  valid <= 1'b0;
        else if (do_recall) valid <= 1'b1;
    end

    assign rd_data = valid ? sram[rd_addr] : '0;

    // R6: SRAM is never written while its copy is invalid
    a_r6_no_write_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> valid);
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl #(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int ERASE_CYC   = 8,
    parameter int PROG_CYC    = 12,
    parameter int RESTORE_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              hs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy,
    output logic              corrupt
);
    logic              ready, erase_done, prog_done, recall_start, recall_done;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    nvs_seq #(
        .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .RESTORE_CYC(RESTORE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .hs_n(hs_n),
        .ready(ready), .busy(busy), .erase_done(erase_done),
        .prog_done(prog_done), .recall_start(recall_start),
        .recall_done(recall_done)
    );

    nvs_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .recall_start(recall_start), .recall_done(recall_done),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hs_n(hs_n),
        .addr(addr), .din(din), .rd_data(rd_data), .rd_addr(rd_addr),
        .dout(dout), .dout_en(dout_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .corrupt(corrupt)
    );

    nvs_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .pwr_lost(!pwr_good),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .do_erase(erase_done), .do_program(prog_done), .do_recall(recall_done)
    );

    // R6: no output drive and no write while busy
    a_r6_no_out_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !busy);
    a_r6_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy);
endmodule

// File: tb/sim_nvs_ctrl.sv
module sim_nvs_ctrl;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int EC = 8;
    localparam int PC = 12;
    localparam int RC = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_good = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hs_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, busy, corrupt;
    int            total = 0;
    int            bad = 0;

    always #5 clk = ~clk;

    nvs_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYC(EC), .PROG_CYC(PC),
               .RESTORE_CYC(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .hs_n(hs_n), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .busy(busy), .corrupt(corrupt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ce_n = 1; oe_n = 1; we_n = 1; hs_n = 1;
    endtask

    task automatic wr_we(input int a, input int d);
        @(negedge clk); addr = AW'(a); din = DW'(d); ce_n = 0; we_n = 0; oe_n = 1;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic wr_ce(input int a, input int d);
        @(negedge clk); addr = AW'(a); din = DW'(d); ce_n = 0; we_n = 0; oe_n = 1;
        @(negedge clk); ce_n = 1;
        @(negedge clk); we_n = 1;
    endtask

    task automatic rd_chk(input int a, input int exp, input string req);
        @(negedge clk); addr = AW'(a); ce_n = 0; oe_n = 0; we_n = 1; hs_n = 1;
        #1;
        check(dout_en == 1'b1 && int'(dout) == exp, req, int'(dout), exp);
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    // counts negedges with busy high, starting at the next negedge
    task automatic count_busy(output int n);
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (busy) n++;
            else if (n > 0) break;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(busy == 0 && dout_en == 0 && corrupt == 0, "R1 reset outputs",
              {busy, dout_en, corrupt}, 0);
        rst_n = 1;
        begin
            int n;
            count_busy(n);
            check(n == RC, "R1 power-up recall length", n, RC);
        end
        rd_chk(5, 0, "R1 SRAM zero after first recall");
    endtask

    task automatic t_rw();
        wr_we(10, 8'hA5);
        wr_we(11, 8'h5A);
        wr_we(12, 8'hFF);
        wr_ce(13, 8'h3C);
        rd_chk(10, 8'hA5, "R3 we-ended write a");
        rd_chk(11, 8'h5A, "R3 we-ended write b");
        rd_chk(12, 8'hFF, "R3 we-ended write c");
        rd_chk(13, 8'h3C, "R3 ce-ended write");
    endtask

    task automatic t_follow();
        int exp_v[4] = '{8'hA5, 8'h5A, 8'hFF, 8'h3C};
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
        for (int i = 0; i < 4; i++) begin
            addr = AW'(10 + i);
            #1;
            check(dout_en && int'(dout) == exp_v[i], "R2 data follows address",
                  int'(dout), exp_v[i]);
            @(negedge clk);
        end
        oe_n = 1; #1;
        check(!dout_en && dout == 0, "R2 oe high stops drive", int'(dout_en), 0);
        @(negedge clk); ce_n = 1;
    endtask

    task automatic t_contention();
        @(negedge clk); addr = 20; din = 8'h61; ce_n = 0; oe_n = 0; we_n = 0;
        #1;
        check(!dout_en, "R4 oe low during write", int'(dout_en), 0);
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1; oe_n = 1;
        rd_chk(20, 8'h61, "R4 write with oe low stored");
    endtask

    task automatic t_store();
        int n = 0;
        int seen = 0;
        wr_we(1, 8'h11);
        wr_we(2, 8'h22);
        @(negedge clk); hs_n = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (busy) begin
                n++; seen = 1;
            end else if (seen) begin
                break;
            end
            if (n == 2) begin
                hs_n = 1; addr = 2; ce_n = 0; oe_n = 0; we_n = 1;
            end
            if (n == 4) begin
                #1;
                check(!dout_en, "R6 no read drive while busy", int'(dout_en), 0);
                oe_n = 1; addr = 1; din = 8'h99; we_n = 0;
            end
            if (n == 7) we_n = 1;
            if (n == 9) ce_n = 1;
        end
        check(n == EC + PC, "R5 store busy length", n, EC + PC);
        rd_chk(1, 8'h11, "R6 write during busy ignored");
        // R9: hold hs_n low across a whole store
        @(negedge clk); hs_n = 0;
        count_busy(n);
        check(n == EC + PC, "R9 second store length", n, EC + PC);
        n = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (busy) n++;
        end
        check(n == 0, "R9 held low starts no store", n, 0);
        idle();
    endtask

    task automatic t_power();
        int n;
        wr_we(1, 8'h55);
        rd_chk(1, 8'h55, "R3 write after store");
        @(negedge clk); pwr_good = 0;
        repeat (2) @(negedge clk);
        addr = 2; ce_n = 0; oe_n = 0; #1;
        check(!busy && !dout_en, "R7 off blocks access", {busy, dout_en}, 0);
        @(negedge clk); ce_n = 1; oe_n = 1; pwr_good = 1;
        count_busy(n);
        check(n == RC, "R7 recall length", n, RC);
        rd_chk(1, 8'h11, "R7 shadow restored a");
        rd_chk(2, 8'h22, "R7 shadow restored b");
        rd_chk(10, 8'hA5, "R7 shadow restored c");
        check(corrupt == 0, "R8 no flag without overlap", int'(corrupt), 0);
    endtask

    task automatic t_corrupt();
        int n;
        @(negedge clk); pwr_good = 0;
        @(negedge clk); addr = 7; din = 8'h77; ce_n = 0; we_n = 0;
        @(negedge clk); pwr_good = 1;
        count_busy(n);
        #1;
        check(corrupt == 1, "R8 flag on overlapping write", int'(corrupt), 1);
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
        rd_chk(7, 0, "R8 overlapped write dropped");
        wr_we(7, 8'h78);
        rd_chk(7, 8'h78, "R8 later write accepted");
        @(negedge clk); pwr_good = 0;
        @(negedge clk); pwr_good = 1;
        count_busy(n);
        check(corrupt == 0, "R8 flag cleared by next recall", int'(corrupt), 0);
    endtask

    initial begin
        t_reset();
        t_rw();
        t_follow();
        t_contention();
        t_store();
        t_power();
        t_corrupt();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule